// File: doc/BRIEF.md
# Single-Step Trace Trap Unit

This unit lets a debugger step through a program one instruction at a time. Software leaves its exception handler through a trap-return sequence. If that sequence writes the trace-mode bit, the unit arms. The instruction being returned to then runs and commits normally. At the commit point of the instruction after it, the unit raises a trace-trap request. That request aborts the instruction and re-enters the handler. The request sits at the top of the exception priority order (priority 0) and is gated by exception enable group 1.

Any exception that is accepted while the unit is armed disarms it. This covers a data-type or overflow trap raised by the returned-to instruction, an asynchronous interrupt taken before that instruction commits, and the trace trap itself. The unit arms again only when a later trap return writes the trace bit. An instruction counts as committed only when the commit strobe is high and no exception is pending or being accepted in that cycle. The parameter `STEPS` sets how many instructions are let through before the trapped one; a value of 1 gives single-step behaviour.

The controller has three states. `TS_IDLE` means disarmed. `TS_ARMED` counts clean commits. `TS_LAST` waits for the commit that gets trapped. The transitions are:
- arm: any state to `TS_ARMED`, on a trace-setting return.
- clear: any state to `TS_IDLE`, on a return without the bit, or on an accepted exception.
- stepped: `TS_ARMED` to `TS_LAST`, on the `STEPS`-th clean commit.
- hold: every other case keeps the current state.

Top module: `trace_step_trap`

## Requirements
- R1: After reset the unit is disarmed and `tt_req` is 0 for every input pattern until an arming return.
- R2: A return strobe with `tt_ret_trace`=1 arms the unit. A return strobe with `tt_ret_trace`=0 leaves it disarmed, so no later commit raises `tt_req`.
- R3: After arming, the first `STEPS` clean commits complete with `tt_req`=0.
- R4: Once `STEPS` clean commits have completed, `tt_req` is 1 in every cycle that has `tt_commit`=1 and `tt_grp1_en`=1. It is raised in the same cycle as the commit strobe and is repeated on each such commit until an exception is accepted.
- R5: A commit cycle in which `tt_other_pend` is 1 does not count toward the `STEPS` instructions.
- R6: A cycle with `tt_exc_taken`=1 disarms the unit. From the next cycle on, `tt_req` stays 0 until a new arming return.
- R7: While `tt_grp1_en` is 0, no request is raised, but the commit count and the waiting state are kept. The first commit after the enable returns raises `tt_req`.
- R8: When `tt_exc_taken` and an arming return occur in the same cycle, the accepted exception wins and the unit stays disarmed.
- R9: An arming return while the unit is already armed restarts the count of `STEPS` instructions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tt_ret | input | 1 | Trap-return strobe, one cycle |
| tt_ret_trace | input | 1 | Trace-mode value written by the return |
| tt_commit | input | 1 | An instruction is at its commit point this cycle |
| tt_other_pend | input | 1 | Some other exception is requested this cycle |
| tt_exc_taken | input | 1 | An exception is accepted this cycle |
| tt_grp1_en | input | 1 | Exception enable group 1 |
| tt_req | output | 1 | Trace-trap request, priority 0 |

## Verification
The bench builds two copies that share the same stimulus: one with `STEPS`=1 (true single-step) and one with `STEPS`=3. The `STEPS`=3 copy makes the counter range a real multi-bit counter. It also reaches the cases where uncounted commits, disabled-enable commits and re-arming returns land in the middle of the count rather than at its only value. In the same stimulus the `STEPS`=1 copy is already in `TS_LAST`, so the two copies give different expected outputs for the same cycles.

// File: rtl/trace_step_pkg.sv
package trace_step_pkg;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_ARMED = 2'd1,
        TS_LAST  = 2'd2
    } ts_state_e;

endpackage

// File: rtl/trace_step_count.sv
module trace_step_count #(
    parameter int STEPS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic done
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(STEPS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (adv && (cnt != LAST_IDX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = adv && (cnt == LAST_IDX);

    // count never passes the final instruction index (R5 counting)
    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_IDX);

    // without a counted commit or a clear, the count holds (R5)
    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(cnt));

endmodule

// File: rtl/trace_step_ctrl.sv
module trace_step_ctrl
    import trace_step_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ret,
    input  logic ret_trace,
    input  logic commit,
    input  logic other_pend,
    input  logic exc_taken,
    input  logic step_done,
    output logic cnt_clr,
    output logic cnt_adv,
    output logic fire_window
);
    ts_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (exc_taken) begin
            state_nx = TS_IDLE;
        end else if (ret) begin
            state_nx = ret_trace ? TS_ARMED : TS_IDLE;
        end else begin
            unique case (state)
                TS_IDLE:  state_nx = TS_IDLE;
                TS_ARMED: state_nx = step_done ? TS_LAST : TS_ARMED;
                TS_LAST:  state_nx = TS_LAST;
                default:  state_nx = TS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        cnt_clr     = 1'b1;
        cnt_adv     = 1'b0;
        fire_window = 1'b0;
        unique case (state)
            TS_IDLE: begin
                cnt_clr = 1'b1;
            end
            TS_ARMED: begin
                cnt_clr = ret || exc_taken;
                cnt_adv = commit && !other_pend && !exc_taken && !ret;
            end
            TS_LAST: begin
                fire_window = 1'b1;
            end
            default: begin
                cnt_clr = 1'b1;
            end
        endcase
    end

    // the waiting state is entered only on a commit cycle (R3)
    p_last_from_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_LAST && $past(state) != TS_LAST) |-> $past(commit));

    // an accepted exception always ends in the idle state (R6)
    p_taken_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> (state == TS_IDLE));

endmodule

// File: rtl/trace_step_gate.sv
module trace_step_gate (
    input  logic fire_window,
    input  logic commit,
    input  logic grp1_en,
    output logic req
);
    assign req = fire_window && commit && grp1_en;
endmodule

// File: rtl/trace_step_trap.sv
module trace_step_trap #(
    parameter int STEPS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tt_ret,
    input  logic tt_ret_trace,
    input  logic tt_commit,
    input  logic tt_other_pend,
    input  logic tt_exc_taken,
    input  logic tt_grp1_en,
    output logic tt_req
);
    logic cnt_clr, cnt_adv, step_done, fire_window;

    trace_step_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ret         (tt_ret),
        .ret_trace   (tt_ret_trace),
        .commit      (tt_commit),
        .other_pend  (tt_other_pend),
        .exc_taken   (tt_exc_taken),
        .step_done   (step_done),
        .cnt_clr     (cnt_clr),
        .cnt_adv     (cnt_adv),
        .fire_window (fire_window)
    );

    trace_step_count #(.STEPS(STEPS)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .adv   (cnt_adv),
        .done  (step_done)
    );

    trace_step_gate u_gate (
        .fire_window (fire_window),
        .commit      (tt_commit),
        .grp1_en     (tt_grp1_en),
        .req         (tt_req)
    );

    // the cycle after an arming return is never trapped (R3)
    p_quiet_after_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tt_ret && tt_ret_trace && !tt_exc_taken) |=> !tt_req);

    // a non-arming return leaves no request behind (R2)
    p_no_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tt_ret && !tt_ret_trace) |=> !tt_req);

    // accepted exception disarms (R6, R8)
    p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tt_exc_taken |=> !tt_req);

endmodule

// File: tb/trace_step_trap_tb.sv
module trace_step_trap_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ret = 1'b0, trc = 1'b0, com = 1'b0, oth = 1'b0, tak = 1'b0, en = 1'b1;
    logic req1, req3;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bit    exp1_q[$];
    bit    exp3_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    trace_step_trap #(.STEPS(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .tt_ret(ret), .tt_ret_trace(trc),
        .tt_commit(com), .tt_other_pend(oth), .tt_exc_taken(tak),
        .tt_grp1_en(en), .tt_req(req1)
    );

    trace_step_trap #(.STEPS(3)) u_dut_s3 (
        .clk(clk), .rst_n(rst_n), .tt_ret(ret), .tt_ret_trace(trc),
        .tt_commit(com), .tt_other_pend(oth), .tt_exc_taken(tak),
        .tt_grp1_en(en), .tt_req(req3)
    );

    task automatic cyc(input bit r, input bit t, input bit c, input bit o,
                       input bit k, input bit e, input bit x1, input bit x3,
                       input string tag);
        @(negedge clk);
        ret = r; trc = t; com = c; oth = o; tak = k; en = e;
        exp1_q.push_back(x1);
        exp3_q.push_back(x3);
        tag_q.push_back(tag);
    endtask

    // monitor: compare each cycle's outputs against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (tag_q.size() > 0) begin
                bit e1, e3;
                string tg;
                e1 = exp1_q.pop_front();
                e3 = exp3_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if (req1 !== e1) begin
                    fails++;
                    $display("FAIL %s STEPS=1 req actual=%b expected=%b", tg, req1, e1);
                end
                checks++;
                if (req3 !== e3) begin
                    fails++;
                    $display("FAIL %s STEPS=3 req actual=%b expected=%b", tg, req3, e3);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (req1 !== 1'b0 || req3 !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset req actual=%b%b expected=00", req1, req3);
        end
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0,0,0,0,0,1, 0,0, "R1");
        cyc(0,0,1,0,0,1, 0,0, "R1");
        cyc(0,0,1,0,0,1, 0,0, "R1");

        // R2/R3/R4: arm, first commit free, second traps (STEPS=1)
        cyc(1,1,0,0,0,1, 0,0, "R2");
        cyc(0,0,1,0,0,1, 0,0, "R3");
        cyc(0,0,0,0,0,1, 0,0, "R3");
        cyc(0,0,1,0,0,1, 1,0, "R4");
        cyc(0,0,0,0,1,1, 0,0, "R6");
        cyc(0,0,1,0,0,1, 0,0, "R6");
        cyc(0,0,1,0,0,1, 0,0, "R6");

        // R4: repeated requests, STEPS=3 fires after three clean commits
        cyc(1,1,0,0,0,1, 0,0, "R2");
        cyc(0,0,1,0,0,1, 0,0, "R3");
        cyc(0,0,1,0,0,1, 1,0, "R4");
        cyc(0,0,1,0,0,1, 1,0, "R4");
        cyc(0,0,1,0,0,1, 1,1, "R4");
        cyc(0,0,0,0,1,1, 0,0, "R6");

        // R2: return without trace bit does not arm
        cyc(1,0,0,0,0,1, 0,0, "R2");
        cyc(0,0,1,0,0,1, 0,0, "R2");
        cyc(0,0,1,0,0,1, 0,0, "R2");
        cyc(0,0,1,0,0,1, 0,0, "R2");
        cyc(0,0,1,0,0,1, 0,0, "R2");

        // R5: commit with other exception pending is not counted
        cyc(1,1,0,0,0,1, 0,0, "R2");
        cyc(0,0,1,1,0,1, 0,0, "R5");
        cyc(0,0,1,0,0,1, 0,0, "R5");
        cyc(0,0,1,0,0,1, 1,0, "R5");
        cyc(0,0,1,0,0,1, 1,0, "R5");
        cyc(0,0,1,0,0,1, 1,1, "R5");
        cyc(0,0,0,0,1,1, 0,0, "R6");

        // R7: enable low suppresses request but keeps count
        cyc(1,1,0,0,0,1, 0,0, "R2");
        cyc(0,0,1,0,0,1, 0,0, "R7");
        cyc(0,0,1,0,0,0, 0,0, "R7");
        cyc(0,0,0,0,0,0, 0,0, "R7");
        cyc(0,0,1,0,0,1, 1,0, "R7");
        cyc(0,0,1,0,0,0, 0,0, "R7");
        cyc(0,0,1,0,0,1, 1,1, "R7");
        cyc(0,0,0,0,1,1, 0,0, "R6");

        // R8: accepted exception wins over arming return
        cyc(1,1,0,0,1,1, 0,0, "R8");
        cyc(0,0,1,0,0,1, 0,0, "R8");
        cyc(0,0,1,0,0,1, 0,0, "R8");
        cyc(0,0,1,0,0,1, 0,0, "R8");
        cyc(0,0,1,0,0,1, 0,0, "R8");

        // R9: re-arming restarts the count
        cyc(1,1,0,0,0,1, 0,0, "R2");
        cyc(0,0,1,0,0,1, 0,0, "R9");
        cyc(0,0,1,0,0,1, 1,0, "R9");
        cyc(1,1,0,0,0,1, 0,0, "R9");
        cyc(0,0,1,0,0,1, 0,0, "R9");
        cyc(0,0,1,0,0,1, 1,0, "R9");
        cyc(0,0,1,0,0,1, 1,0, "R9");
        cyc(0,0,1,0,0,1, 1,1, "R9");
        cyc(0,0,0,0,1,1, 0,0, "R6");

        // R6: exception before any commit disarms
        cyc(1,1,0,0,0,1, 0,0, "R2");
        cyc(0,0,0,0,1,1, 0,0, "R6");
        cyc(0,0,1,0,0,1, 0,0, "R6");
        cyc(0,0,1,0,0,1, 0,0, "R6");
        cyc(0,0,1,0,0,1, 0,0, "R6");
        cyc(0,0,1,0,0,1, 0,0, "R6");
        cyc(0,0,0,0,0,1, 0,0, "R1");

        @(negedge clk);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule